// File: doc/BRIEF.md
# Command Frame Integrity Checker

This block sits behind a byte transport and judges one command at a time. The first byte of a command is the instruction byte. It carries a mode bit for the parallel data path, a bit that selects the accumulator as the first operand, a 3-bit operation code, and a 3-bit CRC over those five bits. The block checks that CRC before anything else, because a corrupted header would give a wrong payload length.

Once the header is accepted, the operation code and the accumulate bit fix how many payload bytes follow. The payload is a control byte plus two bytes for each operand that the stream supplies. Each payload byte is reported with its position. The byte after the payload is compared against a CRC-8 that the block runs over the whole payload. A match gives a one-cycle frame-ok pulse. A mismatch at either level raises a sticky error and drops the frame. A start-of-transaction pulse abandons any partly received frame.

Top module: `cmd_frame_checker`

## Requirements
- R1: Instruction byte layout is bit 7 burst, bit 6 acc, bits 5:3 opcode, bits 2:0 check. The check must equal the CRC of bits 7:3 (MSB first, polynomial x^3+x+1 = 0x3, initial 0) XOR 3'b111. On a mismatch `err_o` is high from the next cycle, no payload strobe follows, and the next byte is again taken as an instruction.
- R2: After an accepted instruction byte, `burst_o`, `acc_o` and `opcode_o` show bits 7, 6 and 5:3 of that byte from the next cycle on. They hold until the next accepted instruction.
- R3: The payload length is 1 + 2 × max(arity − acc, 0). Arity is 2 for opcodes 000, 001, 010, 011 and 110, 1 for opcodes 100 and 101, and 0 for opcode 111.
- R4: Each payload byte accepted gives `pay_stb_o` high for exactly the next cycle. `pay_idx_o` counts 0, 1, 2 … in arrival order, with 0 the control byte.
- R5: The byte after the last payload byte is the check byte. If it equals the CRC-8 of the payload bytes (MSB first, polynomial 0x07, initial 0x00, no reflection, no final XOR), `frame_ok_o` is high for one cycle and `err_o` is low in that cycle.
- R6: If the check byte does not match, `err_o` rises the next cycle, `frame_ok_o` stays low, and the next byte is taken as an instruction.
- R7: `start_i` abandons any partial frame without touching `err_o`. A byte that arrives in the same cycle as `start_i` is treated as an instruction byte.
- R8: `err_clr_i` clears `err_o` on the next cycle. A new error detected in the same cycle takes priority, so `err_o` stays high.
- R9: Cycles with `byte_valid_i` low change nothing, whatever value `byte_i` has.
- R10: After reset `err_o`, `frame_ok_o`, `pay_stb_o`, `burst_o`, `acc_o` and `opcode_o` are 0, and the first valid byte is taken as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-of-transaction pulse |
| byte_valid_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Incoming command byte |
| err_clr_i | input | 1 | Clears the sticky error |
| burst_o | output | 1 | Decoded parallel-path mode bit |
| acc_o | output | 1 | Decoded accumulate bit |
| opcode_o | output | 3 | Decoded operation code |
| pay_stb_o | output | 1 | One-cycle strobe per payload byte |
| pay_idx_o | output | IDX_W (3) | Position of the strobed payload byte |
| frame_ok_o | output | 1 | One-cycle pulse on a fully valid frame |
| err_o | output | 1 | Sticky CRC error flag |

## Verification
The bench builds the block with its default parameters: two bytes per operand and the stated polynomials. This gives a longest payload of five bytes. Every opcode and acc combination can be reached in a few cycles, including the clamped case of a no-operand opcode with acc set. Frames are sent both back to back and with idle cycles that carry junk data. The bench also injects single-bit faults in the header check and in the trailing check byte, raises start in the middle of a payload, and issues an error clear alone and in the same cycle as a fresh fault. This drives every branch of the sequencer against a behavioural model that computes both CRCs by augmented long division.

// File: rtl/cmdchk_pkg.sv
package cmdchk_pkg;

  // Largest number of operands any operation consumes.
  localparam int unsigned MAX_ARITY = 2;

  typedef enum logic [1:0] {
    PH_INSTR   = 2'd0,
    PH_PAYLOAD = 2'd1,
    PH_CHECK   = 2'd2
  } phase_e;

  // Operand count of each operation code.
  function automatic logic [1:0] op_arity(input logic [2:0] op);
    case (op)
      3'b111:         return 2'd0;
      3'b100, 3'b101: return 2'd1;
      default:        return 2'd2;
    endcase
  endfunction

  // Operands delivered by the stream: arity minus acc, floored at zero.
  function automatic logic [1:0] streamed_operands(input logic [2:0] op,
                                                   input logic       acc);
    logic [1:0] ar;
    ar = op_arity(op);
    return (ar > {1'b0, acc}) ? ar - {1'b0, acc} : 2'd0;
  endfunction

endpackage

// File: rtl/cmdchk_crc.sv
// Combinational MSB-first CRC advance over DW data bits.
module cmdchk_crc #(
  parameter int unsigned   W    = 8,
  parameter int unsigned   DW   = 8,
  parameter logic [W-1:0]  POLY = '0
) (
  input  logic [W-1:0]  crc_i,
  input  logic [DW-1:0] data_i,
  output logic [W-1:0]  crc_o
);

  logic [W-1:0] stage [0:DW];

  assign stage[0] = crc_i;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb           = stage[i][W-1] ^ data_i[DW-1-i];
    assign stage[i+1]   = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DW];

endmodule

// File: rtl/cmdchk_decode.sv
// Header decode: field split, header CRC check, payload length.
module cmdchk_decode
  import cmdchk_pkg::*;
#(
  parameter int unsigned OPB         = 2,
  parameter int unsigned LEN_W       = 3,
  parameter logic [2:0]  CRC3_POLY   = 3'h3,
  parameter logic [2:0]  CRC3_XOROUT = 3'h7
) (
  input  logic [7:0]       instr_i,
  output logic             burst_o,
  output logic             acc_o,
  output logic [2:0]       opcode_o,
  output logic             hdr_ok_o,
  output logic [LEN_W-1:0] pay_len_o
);

  logic [2:0] crc_raw;
  logic [1:0] used_ops;

  assign burst_o  = instr_i[7];
  assign acc_o    = instr_i[6];
  assign opcode_o = instr_i[5:3];

  cmdchk_crc #(.W(3), .DW(5), .POLY(CRC3_POLY)) u_hdr_crc (
    .crc_i  (3'b000),
    .data_i (instr_i[7:3]),
    .crc_o  (crc_raw)
  );

  assign hdr_ok_o  = ((crc_raw ^ CRC3_XOROUT) == instr_i[2:0]);
  assign used_ops  = streamed_operands(opcode_o, acc_o);
  assign pay_len_o = LEN_W'(1) + LEN_W'(used_ops) * LEN_W'(OPB);

endmodule

// File: rtl/cmdchk_seq.sv
// Frame sequencer: payload counting, payload CRC-8, verdicts, sticky error.
module cmdchk_seq
  import cmdchk_pkg::*;
#(
  parameter int unsigned MAX_PAY   = 5,
  parameter int unsigned LEN_W     = 3,
  parameter int unsigned IDX_W     = 3,
  parameter logic [7:0]  CRC8_POLY = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             err_clr_i,
  input  logic             hdr_ok_i,
  input  logic             hdr_burst_i,
  input  logic             hdr_acc_i,
  input  logic [2:0]       hdr_op_i,
  input  logic [LEN_W-1:0] hdr_len_i,
  output logic             burst_o,
  output logic             acc_o,
  output logic [2:0]       opcode_o,
  output logic             pay_stb_o,
  output logic [IDX_W-1:0] pay_idx_o,
  output logic             frame_ok_o,
  output logic             err_o
);

  phase_e           ph_q, ph_eff;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic [7:0]       crc_q, crc_step;

  // Named internal events.
  logic instr_take, instr_good, instr_bad;
  logic pay_take, pay_last, chk_take;
  logic frame_good, crc_bad, err_set;

  assign ph_eff     = start_i ? PH_INSTR : ph_q;
  assign instr_take = byte_valid_i && (ph_eff == PH_INSTR);
  assign instr_good = instr_take && hdr_ok_i;
  assign instr_bad  = instr_take && !hdr_ok_i;
  assign pay_take   = byte_valid_i && (ph_eff == PH_PAYLOAD);
  assign chk_take   = byte_valid_i && (ph_eff == PH_CHECK);
  assign pay_last   = (cnt_q == len_q - LEN_W'(1));
  assign frame_good = chk_take && (crc_q == byte_i);
  assign crc_bad    = chk_take && (crc_q != byte_i);
  assign err_set    = instr_bad || crc_bad;

  cmdchk_crc #(.W(8), .DW(8), .POLY(CRC8_POLY)) u_pay_crc (
    .crc_i  (crc_q),
    .data_i (byte_i),
    .crc_o  (crc_step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= PH_INSTR;
      cnt_q      <= '0;
      len_q      <= '0;
      crc_q      <= '0;
      burst_o    <= 1'b0;
      acc_o      <= 1'b0;
      opcode_o   <= '0;
      pay_stb_o  <= 1'b0;
      pay_idx_o  <= '0;
      frame_ok_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      pay_stb_o  <= pay_take;
      frame_ok_o <= frame_good;
      if (pay_take) pay_idx_o <= cnt_q[IDX_W-1:0];

      if (instr_good) begin
        ph_q     <= PH_PAYLOAD;
        cnt_q    <= '0;
        crc_q    <= '0;
        len_q    <= hdr_len_i;
        burst_o  <= hdr_burst_i;
        acc_o    <= hdr_acc_i;
        opcode_o <= hdr_op_i;
      end else if (pay_take) begin
        crc_q <= crc_step;
        cnt_q <= cnt_q + LEN_W'(1);
        ph_q  <= pay_last ? PH_CHECK : PH_PAYLOAD;
      end else if (chk_take) begin
        ph_q <= PH_INSTR;
      end else begin
        ph_q <= ph_eff;
      end

      if (err_set)                      err_o <= 1'b1;
      else if (frame_good || err_clr_i) err_o <= 1'b0;
    end
  end

  // R1
  hdr_bad_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_bad |=> (err_o && !pay_stb_o));

  // R4
  stb_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_stb_o |-> $past(byte_valid_i));

  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_stb_o |-> (pay_idx_o < IDX_W'(MAX_PAY)));

  // R5
  ok_is_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o |=> !frame_ok_o);

  // R5
  ok_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o |-> !err_o);

  // R6
  bad_crc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_bad |=> (err_o && !frame_ok_o));

  // R7
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!pay_stb_o && !frame_ok_o));

  // R8
  clr_drops_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !err_set) |=> !err_o);

endmodule

// File: rtl/cmd_frame_checker.sv
module cmd_frame_checker
  import cmdchk_pkg::*;
#(
  parameter int unsigned  OPB         = 2,
  parameter logic [2:0]   CRC3_POLY   = 3'h3,
  parameter logic [2:0]   CRC3_XOROUT = 3'h7,
  parameter logic [7:0]   CRC8_POLY   = 8'h07,
  localparam int unsigned MAX_PAY     = 1 + MAX_ARITY * OPB,
  localparam int unsigned LEN_W       = $clog2(MAX_PAY + 1),
  localparam int unsigned IDX_W       = $clog2(MAX_PAY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             err_clr_i,
  output logic             burst_o,
  output logic             acc_o,
  output logic [2:0]       opcode_o,
  output logic             pay_stb_o,
  output logic [IDX_W-1:0] pay_idx_o,
  output logic             frame_ok_o,
  output logic             err_o
);

  logic             hdr_burst, hdr_acc, hdr_ok;
  logic [2:0]       hdr_op;
  logic [LEN_W-1:0] hdr_len;

  cmdchk_decode #(
    .OPB(OPB), .LEN_W(LEN_W), .CRC3_POLY(CRC3_POLY), .CRC3_XOROUT(CRC3_XOROUT)
  ) u_decode (
    .instr_i   (byte_i),
    .burst_o   (hdr_burst),
    .acc_o     (hdr_acc),
    .opcode_o  (hdr_op),
    .hdr_ok_o  (hdr_ok),
    .pay_len_o (hdr_len)
  );

  cmdchk_seq #(
    .MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .IDX_W(IDX_W), .CRC8_POLY(CRC8_POLY)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .err_clr_i    (err_clr_i),
    .hdr_ok_i     (hdr_ok),
    .hdr_burst_i  (hdr_burst),
    .hdr_acc_i    (hdr_acc),
    .hdr_op_i     (hdr_op),
    .hdr_len_i    (hdr_len),
    .burst_o      (burst_o),
    .acc_o        (acc_o),
    .opcode_o     (opcode_o),
    .pay_stb_o    (pay_stb_o),
    .pay_idx_o    (pay_idx_o),
    .frame_ok_o   (frame_ok_o),
    .err_o        (err_o)
  );

endmodule

// File: tb/cmd_frame_checker_bench.sv
module cmd_frame_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, valid = 1'b0, clr = 1'b0;
  logic [7:0] din = 8'h00;
  logic burst, acc, stb, fok, err;
  logic [2:0] op;
  logic [IDX_W-1:0] idx;

  cmd_frame_checker u_cmd_frame_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_valid_i(valid),
    .byte_i(din), .err_clr_i(clr), .burst_o(burst), .acc_o(acc),
    .opcode_o(op), .pay_stb_o(stb), .pay_idx_o(idx), .frame_ok_o(fok),
    .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0, gap = 0;
  string cur_req = "R10";
  bit done = 0;

  // Reference CRCs by augmented long division.
  function automatic logic [2:0] ref_crc3(input logic [4:0] d);
    int r = 0;
    for (int i = 7; i >= 0; i--) begin
      r = (r << 1) | ((i >= 3) ? int'(d[i-3]) : 0);
      if (r & 8) r ^= 'hB;
    end
    return 3'(r) ^ 3'b111;
  endfunction

  function automatic logic [7:0] ref_crc8(input byte unsigned q[$]);
    int r = 0;
    for (int k = 0; k < q.size() + 1; k++)
      for (int b = 7; b >= 0; b--) begin
        r = (r << 1) | ((k < q.size()) ? ((q[k] >> b) & 1) : 0);
        if (r & 'h100) r ^= 'h107;
      end
    return 8'(r);
  endfunction

  function automatic int operand_bytes(input logic [2:0] o, input logic a);
    int n;
    if (o == 3'd7) n = 0;
    else if (o == 3'd4 || o == 3'd5) n = 1;
    else n = 2;
    n = n - int'(a);
    if (n < 0) n = 0;
    return 2 * n;
  endfunction

  // Behavioural model, advanced on each rising edge.
  int m_phase = 0, m_len = 0, m_idx = 0;
  byte unsigned m_q[$];
  bit m_burst = 0, m_acc = 0, m_stb = 0, m_ok = 0, m_err = 0, seterr;
  bit [2:0] m_op = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_err = 0; m_ok = 0; m_stb = 0; m_idx = 0;
      m_burst = 0; m_acc = 0; m_op = 0; m_q.delete();
    end else begin
      seterr = 0; m_ok = 0; m_stb = 0;
      if (start) m_phase = 0;
      if (valid) begin
        if (m_phase == 0) begin
          if (din[2:0] == ref_crc3(din[7:3])) begin
            m_burst = din[7]; m_acc = din[6]; m_op = din[5:3];
            m_len = 1 + operand_bytes(din[5:3], din[6]);
            m_q.delete(); m_phase = 1;
          end else seterr = 1;
        end else if (m_phase == 1) begin
          m_q.push_back(din); m_stb = 1; m_idx = m_q.size() - 1;
          if (m_q.size() == m_len) m_phase = 2;
        end else begin
          if (din == ref_crc8(m_q)) m_ok = 1; else seterr = 1;
          m_phase = 0;
        end
      end
      if (seterr) m_err = 1;
      else if (m_ok || clr) m_err = 0;
    end
  end

  task automatic check(string sig, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  bit cmp_en = 0;
  always @(negedge clk) if (cmp_en && !done) begin
    check("err_o", err, m_err);
    check("frame_ok_o", fok, m_ok);
    check("pay_stb_o", stb, m_stb);
    if (m_stb) check("pay_idx_o", idx, m_idx);
    check("burst_o", burst, m_burst);
    check("acc_o", acc, m_acc);
    check("opcode_o", op, m_op);
  end

  task automatic cyc(bit v, logic [7:0] b, bit s, bit c);
    @(negedge clk); #1;
    valid = v; din = b; start = s; clr = c;
  endtask

  task automatic send(logic [7:0] b);
    cyc(1, b, 0, 0);
    for (int g = 0; g < gap; g++) cyc(0, 8'($urandom), 0, 0);
  endtask

  task automatic frame(bit bu, bit ac, logic [2:0] o, bit bad_hdr, bit bad_crc);
    byte unsigned q[$];
    logic [7:0] ins;
    ins = {bu, ac, o, ref_crc3({bu, ac, o})};
    if (bad_hdr) ins[0] = ~ins[0];
    send(ins);
    if (bad_hdr) return;
    for (int k = 0; k < 1 + operand_bytes(o, ac); k++) begin
      q.push_back(8'($urandom));
      send(q[k]);
    end
    send(ref_crc8(q) ^ (bad_crc ? 8'h01 : 8'h00));
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (3) cyc(0, 8'h00, 0, 0);
    cmp_en = 1;
    repeat (2) cyc(0, 8'h00, 0, 0);
    rst_n = 1;
    cyc(0, 8'h00, 0, 0);

    // R2 R3 R4 R5: every opcode and mode, back to back and with idle gaps
    cur_req = "R2 R3 R4 R5";
    for (int g = 0; g < 2; g++) begin
      gap = g * 2;
      for (int m = 0; m < 4; m++)
        for (int o = 0; o < 8; o++) frame(m[1], m[0], 3'(o), 0, 0);
    end

    // R9: idle cycles carry junk bytes
    cur_req = "R9"; gap = 3;
    frame(0, 0, 3'd2, 0, 0);
    frame(1, 1, 3'd7, 0, 0);
    gap = 0;

    // R1: corrupted header check
    cur_req = "R1";
    frame(0, 0, 3'd0, 1, 0);
    frame(1, 0, 3'd6, 1, 0);
    frame(0, 1, 3'd3, 0, 0);

    // R6: corrupted payload check
    cur_req = "R6";
    frame(0, 0, 3'd1, 0, 1);
    frame(0, 1, 3'd4, 0, 1);
    frame(1, 0, 3'd5, 0, 0);

    // R8: clear alone, then clear together with a fresh header fault
    cur_req = "R8";
    frame(0, 0, 3'd7, 0, 1);
    cyc(0, 8'h00, 0, 1);
    cyc(0, 8'h00, 0, 0);
    frame(0, 0, 3'd6, 0, 1);
    cyc(1, {5'b00000, ~ref_crc3(5'b00000)}, 0, 1);
    cyc(0, 8'h00, 0, 0);
    cyc(0, 8'h00, 0, 1);

    // R7: start in mid-payload, with and without a byte in the same cycle
    cur_req = "R7";
    send({2'b00, 3'd2, ref_crc3({2'b00, 3'd2})});
    send(8'h11); send(8'h22);
    cyc(1, {2'b10, 3'd4, ref_crc3({2'b10, 3'd4})}, 1, 0);
    send(8'h33); send(8'h44); send(8'h55);
    send(ref_crc8('{8'h33, 8'h44, 8'h55}));
    frame(0, 0, 3'd0, 0, 1);
    send({2'b01, 3'd1, ref_crc3({2'b01, 3'd1})});
    send(8'h66);
    cyc(0, 8'h00, 1, 0);
    frame(0, 1, 3'd1, 0, 0);

    repeat (3) cyc(0, 8'h00, 0, 0);
    summary();
  end
endmodule